// File: doc/BRIEF.md
# Two-Wire Command-Pointer Register Slave

This block is the serial front end of a small sensor-style register file. It watches a two-wire bus (clock and bidirectional data with an open-drain pull-down enable), decodes its own 7-bit slave address, and moves bytes between the bus master and a 16-entry, byte-wide register file through a simple read/write port. The slave address is strapped by a three-level select input. A fixed alert-response address is also answered, whatever the select level.

Every byte the master writes after the address is sorted by its top bit. A byte with the top bit set is a command: its low four bits load a stored register pointer, and nothing is written. A byte with the top bit clear is data, and it is written to the register at the pointer plus a per-transaction offset. The offset starts at zero on every START and steps after each data byte, wrapping within the 16 entries.

Reads start from the stored pointer and step the offset after each byte that the master acknowledges. So a bare one-byte read (receive byte) always returns the pointed register, and word and block reads walk upward through the registers. This covers the SMBus send, receive, byte, word and block transfers, as well as I2C writes and combined-format reads with a repeated START.

Top module: `twowire_regslave`

## Requirements
- R1: The own address is 0x29 (7-bit) when `addr_lvl` is 2'b00 (ground), 0x39 when it is 2'b01 (floating) and 0x49 when it is 2'b10 (tied high); 2'b11 is treated as floating. The address byte carries the 7-bit address in bits 7..1 and read(1)/write(0) in bit 0. A matching address is ACKed by pulling SDA low in the ninth clock.
- R2: The alert-response address 0x0C is ACKed at every `addr_lvl` setting.
- R3: A non-matching address is NACKed, and the slave leaves SDA released until the next START.
- R4: A written byte with bit 7 = 1 is a command. Its bits 3..0 load the stored pointer, the offset is cleared, no register write occurs, and the byte is ACKed.
- R5: A written byte with bit 7 = 0 is ACKed and written (a one-cycle `reg_we` pulse) to register pointer+offset. The offset then increments, wrapping from 15 to 0.
- R6: A read transfer returns the register at the stored pointer first, MSB first. Each master ACK advances to the next register. A new transaction starts again at the stored pointer, so repeated receive-byte reads return the same register.
- R7: A combined-format read (write address, command, repeated START, read address) returns data from the register selected by that command.
- R8: A master NACK after a read byte ends the read. The slave keeps SDA released until the next START, and a STOP returns it to idle.
- R9: A START or repeated START in the middle of a byte discards that byte and restarts address reception.
- R10: `sda_oe` changes only while the synchronised SCL is low.
- R11: After reset `sda_oe` and `reg_we` are 0, and the stored pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 = pull SDA low |
| addr_lvl | input | 2 | Address strap level: 00 ground, 01 floating, 10 high, 11 as floating |
| reg_addr | output | PTR_W | Register file address (pointer + offset) |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register file read data at `reg_addr` |

## Verification
A stale pointer or offset shows up one byte later as wrong read data, or as a write landing in the wrong register. The bench exposes both by reading back through combined and receive-byte reads. A bit counter or state that drifts out of step shows within the same byte as an ACK missing from the ninth clock, or as SDA held low where the master expects release, for example after an address NACK, a master NACK or a mid-byte START. The timing of the output enable against SCL is watched every cycle, so a change made while the clock is high is flagged at that same edge.

// File: rtl/twl_pkg.sv
package twl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WR,
        ST_WACK,
        ST_RD,
        ST_RACK,
        ST_RNEXT
    } twl_state_e;
endpackage

// File: rtl/twl_line_sync.sv
module twl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_p_q, sda_p_q;
    logic              scl_l_q, sda_l_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= '1;
            sda_p_q <= '1;
            scl_l_q <= 1'b1;
            sda_l_q <= 1'b1;
        end else begin
            scl_p_q <= {scl_p_q[STAGES-2:0], scl_i};
            sda_p_q <= {sda_p_q[STAGES-2:0], sda_i};
            scl_l_q <= scl_s;
            sda_l_q <= sda_s;
        end
    end

    assign scl_s     = scl_p_q[STAGES-1];
    assign sda_s     = sda_p_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_l_q;
    assign scl_fall  = ~scl_s & scl_l_q;
    // data edges while the clock stays high mark bus conditions
    assign start_det = scl_s & scl_l_q & sda_l_q & ~sda_s;
    assign stop_det  = scl_s & scl_l_q & ~sda_l_q & sda_s;
endmodule

// File: rtl/twl_addr_match.sv
module twl_addr_match #(
    parameter logic [6:0] A_GND   = 7'h29,
    parameter logic [6:0] A_FLT   = 7'h39,
    parameter logic [6:0] A_VDD   = 7'h49,
    parameter logic [6:0] A_ALERT = 7'h0C
) (
    input  logic [1:0] lvl,
    input  logic [6:0] addr,
    output logic       hit
);
    logic [6:0] own;

    always_comb begin
        case (lvl)
            2'b00:   own = A_GND;
            2'b10:   own = A_VDD;
            default: own = A_FLT;
        endcase
    end

    assign hit = (addr == own) || (addr == A_ALERT);
endmodule

// File: rtl/twowire_regslave.sv
module twowire_regslave #(
    parameter int         PTR_W       = 4,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] ADDR_GND    = 7'h29,
    parameter logic [6:0] ADDR_FLT    = 7'h39,
    parameter logic [6:0] ADDR_VDD    = 7'h49,
    parameter logic [6:0] ADDR_ALERT  = 7'h0C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [1:0]       addr_lvl,
    output logic [PTR_W-1:0] reg_addr,
    output logic             reg_we,
    output logic [7:0]       reg_wdata,
    input  logic [7:0]       reg_rdata
);
    import twl_pkg::*;

    localparam int         BYTE_W   = 8;
    localparam int         CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        twl_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              rw;
        logic [PTR_W-1:0]  ptr;
        logic [PTR_W-1:0]  off;
        logic              oe;
        logic              we;
        logic [BYTE_W-1:0] wdata;
    } twl_regs_t;

    twl_regs_t q, n;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, hit;

    twl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twl_addr_match #(
        .A_GND   (ADDR_GND),
        .A_FLT   (ADDR_FLT),
        .A_VDD   (ADDR_VDD),
        .A_ALERT (ADDR_ALERT)
    ) u_match (
        .lvl  (addr_lvl),
        .addr (q.sh[7:1]),
        .hit  (hit)
    );

    always_comb begin
        n    = q;
        n.we = 1'b0;
        // step the offset in the cycle after a write so the strobe sees the old address
        if (q.we) n.off = q.off + 1'b1;
        if (start_det) begin
            n.st  = ST_ADDR;
            n.cnt = '0;
            n.off = '0;
            n.oe  = 1'b0;
        end else if (stop_det) begin
            n.st = ST_IDLE;
            n.oe = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_WR: begin
                    if (scl_rise && q.cnt != CNT_FULL) begin
                        n.sh  = {q.sh[BYTE_W-2:0], sda_s};
                        n.cnt = q.cnt + CNT_ONE;
                    end else if (scl_fall && q.cnt == CNT_FULL) begin
                        n.cnt = '0;
                        if (q.st == ST_ADDR) begin
                            if (hit) begin
                                n.oe = 1'b1;
                                n.rw = q.sh[0];
                                n.st = ST_AACK;
                            end else begin
                                n.st = ST_IDLE;
                            end
                        end else begin
                            n.oe = 1'b1;
                            n.st = ST_WACK;
                            if (q.sh[BYTE_W-1]) begin
                                n.ptr = q.sh[PTR_W-1:0];
                                n.off = '0;
                            end else begin
                                n.we    = 1'b1;
                                n.wdata = q.sh;
                            end
                        end
                    end
                end
                ST_AACK, ST_RNEXT: begin
                    if (scl_fall) begin
                        if (q.st == ST_RNEXT || q.rw) begin
                            n.sh  = reg_rdata;
                            n.oe  = ~reg_rdata[BYTE_W-1];
                            n.cnt = '0;
                            n.st  = ST_RD;
                        end else begin
                            n.oe = 1'b0;
                            n.st = ST_WR;
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        n.oe = 1'b0;
                        n.st = ST_WR;
                    end
                end
                ST_RD: begin
                    if (scl_rise) begin
                        n.cnt = q.cnt + CNT_ONE;
                    end else if (scl_fall) begin
                        if (q.cnt == CNT_FULL) begin
                            n.oe = 1'b0;
                            n.st = ST_RACK;
                        end else begin
                            n.sh = {q.sh[BYTE_W-2:0], 1'b0};
                            n.oe = ~q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        if (sda_s) begin
                            n.st = ST_IDLE;
                        end else begin
                            n.off = q.off + 1'b1;
                            n.st  = ST_RNEXT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, sh: '0, rw: 1'b0, ptr: '0,
                   off: '0, oe: 1'b0, we: 1'b0, wdata: '0};
        end else begin
            q <= n;
        end
    end

    assign sda_oe    = q.oe;
    assign reg_we    = q.we;
    assign reg_wdata = q.wdata;
    assign reg_addr  = q.ptr + q.off;
endmodule

// File: rtl/twl_checker.sv
module twl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       sda_oe,
    input logic       reg_we,
    input logic [7:0] reg_wdata,
    input logic       start_det,
    input logic       stop_det
);
    p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s)
        else $error("sda_oe changed while SCL high");

    p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we)
        else $error("write strobe longer than one cycle");

    p_cmd_not_written_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !reg_wdata[7])
        else $error("command byte reached register file");

    p_start_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe)
        else $error("SDA held after START");

    p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe)
        else $error("SDA held after STOP");
endmodule

bind twowire_regslave twl_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_oe    (sda_oe),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .start_det (start_det),
    .stop_det  (stop_det)
);

// File: tb/sim_twowire_regslave.sv
`timescale 1ns/1ps
module sim_twowire_regslave;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [1:0] addr_lvl = 2'b00;
    logic       sda_oe, reg_we;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] mem [16];
    logic       sda_line;
    int         n_chk = 0;
    int         n_fail = 0;

    always #10 clk = ~clk;

    assign sda_line  = m_sda & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= 8'(8'h40 + i);
        end else if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
        end
    end

    twowire_regslave u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .addr_lvl  (addr_lvl),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic bit_cycle(input logic b, output logic r);
        m_sda = b;    tick(Q);
        m_scl = 1'b1; tick(Q);
        r = sda_line; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], r);
        bit_cycle(1'b1, r);
        ack = ~r;
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] b);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, r);
            b[i] = r;
        end
        bit_cycle(~m_ack, r);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        logic a;
        chk("R11 sda_oe", 16'(sda_oe), 16'h0);
        chk("R11 reg_we", 16'(reg_we), 16'h0);
        chk("R11 reg_addr", 16'(reg_addr), 16'h0);
        bus_start(); send_byte({7'h29, 1'b1}, a);
        recv_byte(1'b0, d); bus_stop();
        chk("R11 pointer 0 receive byte", 16'(d), 16'h40);
    endtask

    task automatic t_levels();
        logic a;
        logic [6:0] exp_a [4] = '{7'h29, 7'h39, 7'h49, 7'h39};
        for (int l = 0; l < 4; l++) begin
            addr_lvl = 2'(l);
            bus_start(); send_byte({exp_a[l], 1'b0}, a); bus_stop();
            chk("R1 own address ack", 16'(a), 16'h1);
        end
        addr_lvl = 2'b00;
        bus_start(); send_byte({7'h39, 1'b0}, a);
        chk("R3 foreign address nack", 16'(a), 16'h0);
        send_byte(8'h00, a);
        chk("R3 no ack until START", 16'(a), 16'h0);
        bus_stop();
    endtask

    task automatic t_alert();
        logic a;
        for (int l = 0; l < 3; l++) begin
            addr_lvl = 2'(l);
            bus_start(); send_byte({7'h0C, 1'b0}, a); bus_stop();
            chk("R2 alert address ack", 16'(a), 16'h1);
        end
        addr_lvl = 2'b00;
    endtask

    task automatic t_write_wrap();
        logic a;
        bus_start(); send_byte({7'h29, 1'b0}, a);
        send_byte(8'h8E, a); chk("R4 command ack", 16'(a), 16'h1);
        send_byte(8'h11, a); chk("R5 data ack", 16'(a), 16'h1);
        send_byte(8'h22, a); chk("R5 data ack", 16'(a), 16'h1);
        send_byte(8'h33, a); chk("R5 data ack wrap", 16'(a), 16'h1);
        bus_stop();
    endtask

    task automatic t_combined();
        logic a;
        logic [7:0] d0, d1, d2;
        bus_start(); send_byte({7'h29, 1'b0}, a); send_byte(8'h8E, a);
        bus_start(); send_byte({7'h29, 1'b1}, a);
        chk("R7 read address ack", 16'(a), 16'h1);
        recv_byte(1'b1, d0); recv_byte(1'b1, d1); recv_byte(1'b0, d2);
        bus_stop();
        chk("R7 first byte reg14", 16'(d0), 16'h11);
        chk("R5 second byte reg15", 16'(d1), 16'h22);
        chk("R5 wrapped byte reg0", 16'(d2), 16'h33);
    endtask

    task automatic t_receive_byte();
        logic a;
        logic [7:0] d;
        bus_start(); send_byte({7'h29, 1'b0}, a); send_byte(8'h83, a); bus_stop();
        bus_start(); send_byte({7'h29, 1'b1}, a); recv_byte(1'b0, d); bus_stop();
        chk("R4 command loads pointer only", 16'(d), 16'h43);
        bus_start(); send_byte({7'h29, 1'b1}, a); recv_byte(1'b0, d); bus_stop();
        chk("R6 repeated receive byte", 16'(d), 16'h43);
    endtask

    task automatic t_read_nack();
        logic a;
        logic [7:0] d;
        bus_start(); send_byte({7'h29, 1'b1}, a); recv_byte(1'b0, d);
        chk("R8 byte before nack", 16'(d), 16'h43);
        recv_byte(1'b0, d);
        chk("R8 released after nack", 16'(d), 16'hFF);
        bus_stop();
        chk("R8 idle after stop", 16'(sda_oe), 16'h0);
    endtask

    task automatic t_abort();
        logic a, r;
        logic [7:0] d0, d1;
        bus_start();
        bit_cycle(1'b1, r); bit_cycle(1'b0, r); bit_cycle(1'b1, r); bit_cycle(1'b0, r);
        bus_start(); send_byte({7'h29, 1'b0}, a);
        chk("R9 address after mid-byte start", 16'(a), 16'h1);
        send_byte(8'h5A, a); bus_stop();
        bus_start(); send_byte({7'h29, 1'b1}, a);
        recv_byte(1'b1, d0); recv_byte(1'b0, d1); bus_stop();
        chk("R9 write after abort", 16'(d0), 16'h5A);
        chk("R6 word read increments", 16'(d1), 16'h44);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_levels();
        t_alert();
        t_write_wrap();
        t_combined();
        t_receive_byte();
        t_read_nack();
        t_abort();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule